// File: doc/BRIEF.md
# Maskable Read-to-Clear Interrupt Collector

This block gathers one-cycle event pulses from up to eight internal causes into a sticky status word and drives one external interrupt pin from it. A mask word picks which recorded causes may raise the pin. A separate recording-mode bit picks whether status captures only the masked-in causes or every cause. A polarity bit picks whether the pin is active high or active low. A host reads the status through a read strobe. That read returns the word, acknowledges the interrupt, and empties the status register in one step.

A small write port loads the mask word and a configuration word. The configuration word holds the recording mode, the pin polarity and a pin-function select. When the pin-function select is set, the pin carries an external buffer-empty level instead of the interrupt. Events keep collecting between reads, so a single read can return several causes together. One example is a frame-end cause with an address-match cause pulsed in the same cycle.

Top module: `evt_irq_top`

## Requirements
- R1: After reset the status word is 0, the mask is 0, the recording mode is 0, the polarity is active high and the pin function is interrupt, so the pin is low and a read returns 0.
- R2: With polarity 0 and the interrupt function selected, the pin is high exactly when (status AND mask) is nonzero.
- R3: With recording mode 0, an event on a cause whose mask bit is 0 is not recorded: it does not raise the pin, and a later read returns 0 for that bit.
- R4: With recording mode 1, every event is recorded in status whatever its mask bit. A recorded cause whose mask bit is 0 does not raise the pin.
- R5: With polarity 1 the pin level is inverted: high while (status AND mask) is zero, low otherwise.
- R6: A cycle with rdEn high makes rdValid high in the next cycle, with rdData equal to the status word as it stood in the rdEn cycle. Status is cleared at that same edge, which sends the pin to its inactive level unless new events arrive.
- R7: Recorded bits stay set until a read. Events on different causes in different cycles all appear together in one read.
- R8: An event that arrives in the same cycle as a read is absent from that read's data and stays set in status afterwards.
- R9: With the pin-function select set, the pin follows bufEmpty directly. Status recording carries on unchanged, and the interrupt level reappears when the select is cleared.
- R10: Cause positions are fixed: bit 3 is frame end and bit 5 is address match. Both pulsed in one cycle are returned together in one read.
- R11: A write with wrSel=0 loads the mask from wrData. A write with wrSel=1 loads the configuration: bit 0 is the recording mode, bit 1 the polarity, bit 2 the pin-function select. Writes with wrSel=2 or 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 8 | One-cycle event pulses, one bit per cause |
| bufEmpty | input | 1 | External buffer-empty level for the alternate pin function |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 mask, 1 configuration |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Status read and acknowledge strobe |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | 8 | Status word returned by the read |
| irqPin | output | 1 | Interrupt or buffer-empty pin |

## Verification
Recording a new event and clearing on a read can both fall on the same clock edge, and they act on the same status bits. The bench provokes this by pulsing one cause in the cycle after another cause was recorded, with rdEn high in that cycle. It then expects the first read to return only the older cause. It expects the pin to stay active and a second read to return only the newer cause. The frame-end and address-match pulses are also sent in one cycle, to judge that simultaneous causes merge into one word.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int CAUSE_W = 8;
  localparam int SEL_W   = 2;

  localparam int CAUSE_CLK_LOCK   = 0;
  localparam int CAUSE_CLK_UNLOCK = 1;
  localparam int CAUSE_RX_START   = 2;
  localparam int CAUSE_FRAME_END  = 3;
  localparam int CAUSE_CCA_DONE   = 4;
  localparam int CAUSE_ADDR_MATCH = 5;
  localparam int CAUSE_UNDERRUN   = 6;
  localparam int CAUSE_WAKE       = 7;

  localparam logic [SEL_W-1:0] SEL_MASK = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CFG  = 2'd1;

  localparam int CFG_REC_ALL = 0;
  localparam int CFG_ACT_LOW = 1;
  localparam int CFG_ALT_PIN = 2;
  localparam int CFG_W       = 3;

  typedef struct packed {
    logic ldMask;
    logic clrStat;
    logic recAll;
    logic activeLow;
    logic altPin;
  } irqCtl_t;
endpackage

// File: rtl/evt_irq_ctrl_unit.sv
module evt_irq_ctrl_unit
  import evt_irq_pkg::*;
#(
  parameter int SELW = SEL_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [SELW-1:0]     wrSel,
  input  logic [CFG_W-1:0]    cfgIn,
  input  logic                rdEn,
  output irqCtl_t             ctl
);
  logic [CFG_W-1:0] cfgQ;
  logic             cfgLoad;

  assign cfgLoad = wrEn && (wrSel == SELW'(SEL_CFG));

  always_ff @(posedge clk) begin
    if (!rstN) cfgQ <= '0;
    else if (cfgLoad) cfgQ <= cfgIn;
  end

  always_comb begin
    ctl           = '0;
    ctl.ldMask    = wrEn && (wrSel == SELW'(SEL_MASK));
    ctl.clrStat   = rdEn;
    ctl.recAll    = cfgQ[CFG_REC_ALL];
    ctl.activeLow = cfgQ[CFG_ACT_LOW];
    ctl.altPin    = cfgQ[CFG_ALT_PIN];
  end

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cfgLoad |=> $stable(cfgQ));
endmodule

// File: rtl/evt_irq_datapath.sv
module evt_irq_datapath
  import evt_irq_pkg::*;
#(
  parameter int NCAUSE = CAUSE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqCtl_t           ctl,
  input  logic [NCAUSE-1:0] wrData,
  input  logic [NCAUSE-1:0] evtPulse,
  input  logic              bufEmpty,
  output logic              rdValid,
  output logic [NCAUSE-1:0] rdData,
  output logic              irqPin
);
  logic [NCAUSE-1:0] maskQ;
  logic [NCAUSE-1:0] statusQ;
  logic [NCAUSE-1:0] pendHit;
  logic              irqActive;

  always_ff @(posedge clk) begin
    if (!rstN) maskQ <= '0;
    else if (ctl.ldMask) maskQ <= wrData;
  end

  for (genvar i = 0; i < NCAUSE; i++) begin : g_cause
    logic recEn;
    assign recEn = ctl.recAll | maskQ[i];
    always_ff @(posedge clk) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else statusQ[i] <= (statusQ[i] & ~ctl.clrStat) | (evtPulse[i] & recEn);
    end
    assign pendHit[i] = statusQ[i] & maskQ[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= ctl.clrStat;
      if (ctl.clrStat) rdData <= statusQ;
    end
  end

  assign irqActive = |pendHit;
  assign irqPin    = ctl.altPin ? bufEmpty : (irqActive ^ ctl.activeLow);

  assert_pin_needs_cause_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.altPin && !ctl.activeLow && irqPin) |-> (statusQ != '0));
  assert_idle_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.altPin && ctl.activeLow && statusQ == '0) |-> irqPin);
  assert_filter_R3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.recAll |=> ((statusQ & ~$past(statusQ) & ~$past(maskQ)) == '0));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.clrStat |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.clrStat && evtPulse == '0) |=> (statusQ == '0));
  assert_keep_new_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clrStat |=> ((statusQ & ~$past(evtPulse)) == '0));
endmodule

// File: rtl/evt_irq_top.sv
module evt_irq_top
  import evt_irq_pkg::*;
#(
  parameter int NCAUSE = CAUSE_W,
  parameter int SELW   = SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCAUSE-1:0] evtPulse,
  input  logic              bufEmpty,
  input  logic              wrEn,
  input  logic [SELW-1:0]   wrSel,
  input  logic [NCAUSE-1:0] wrData,
  input  logic              rdEn,
  output logic              rdValid,
  output logic [NCAUSE-1:0] rdData,
  output logic              irqPin
);
  irqCtl_t ctl;

  evt_irq_ctrl_unit #(.SELW(SELW)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .wrSel (wrSel),
    .cfgIn (wrData[CFG_W-1:0]),
    .rdEn  (rdEn),
    .ctl   (ctl)
  );

  evt_irq_datapath #(.NCAUSE(NCAUSE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrData   (wrData),
    .evtPulse (evtPulse),
    .bufEmpty (bufEmpty),
    .rdValid  (rdValid),
    .rdData   (rdData),
    .irqPin   (irqPin)
  );
endmodule

// File: tb/evt_irq_top_bench.sv
module evt_irq_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] evtPulse = '0;
  logic       bufEmpty = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic       rdValid;
  logic [7:0] rdData;
  logic       irqPin;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [7:0] mdlStat = '0;
  logic [7:0] mdlMask = '0;
  logic       mdlAll  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_top u_evt_irq_top (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .bufEmpty(bufEmpty),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .rdEn(rdEn),
    .rdValid(rdValid), .rdData(rdData), .irqPin(irqPin)
  );

  // monitor: pop an expected read word whenever the design presents one
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected rdValid: actual %02h expected none", rdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (rdData !== it.val) begin
          errors++;
          $display("FAIL %s read: actual %02h expected %02h", it.tag, rdData, it.val);
        end
      end
    end
  end

  task automatic cyc(input logic [7:0] e, input logic rd, input string tag);
    @(negedge clk);
    evtPulse = e;
    rdEn = rd;
    if (rd) expQ.push_back('{val: mdlStat, tag: tag});
    mdlStat = (rd ? 8'h00 : mdlStat) | (e & (mdlAll ? 8'hFF : mdlMask));
    @(posedge clk);
    #1;
    evtPulse = '0;
    rdEn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    if (sel == 2'd0) mdlMask = d;
    if (sel == 2'd1) mdlAll = d[0];
    @(posedge clk);
    #1;
    wrEn = 1'b0; wrSel = '0; wrData = '0;
  endtask

  task automatic chkPin(input logic exp, input string tag);
    @(negedge clk);
    #1;
    checks++;
    if (irqPin !== exp) begin
      errors++;
      $display("FAIL %s pin: actual %b expected %b", tag, irqPin, exp);
    end
  endtask

  task automatic finish_run();
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL drain: actual %0d pending reads expected 0", expQ.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    chkPin(1'b0, "R1");
    cyc(8'h00, 1'b1, "R1");

    // R2 masked frame end raises pin; R6 read clears and drops pin
    wr(2'd0, 8'h08);
    cyc(8'h08, 1'b0, "R2");
    chkPin(1'b1, "R2");
    cyc(8'h00, 1'b1, "R6");
    chkPin(1'b0, "R6");

    // R3 mode 0 drops unmasked cause
    cyc(8'h01, 1'b0, "R3");
    chkPin(1'b0, "R3");
    cyc(8'h00, 1'b1, "R3");

    // R11 writes to unused selects change nothing
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'hFF);
    cyc(8'h01, 1'b0, "R11");
    chkPin(1'b0, "R11");
    cyc(8'h00, 1'b1, "R11");

    // R7 accumulation across cycles
    wr(2'd0, 8'hFF);
    cyc(8'h04, 1'b0, "R7");
    cyc(8'h10, 1'b0, "R7");
    chkPin(1'b1, "R7");
    cyc(8'h00, 1'b1, "R7");

    // R8 event coincident with read survives
    cyc(8'h02, 1'b0, "R8");
    cyc(8'h40, 1'b1, "R8");
    chkPin(1'b1, "R8");
    cyc(8'h00, 1'b1, "R8");
    chkPin(1'b0, "R8");

    // R4 mode 1 records unmasked, pin only for masked
    wr(2'd0, 8'h08);
    wr(2'd1, 8'h01);
    cyc(8'h20, 1'b0, "R4");
    chkPin(1'b0, "R4");
    cyc(8'h00, 1'b1, "R4");

    // R10 frame end and address match in one cycle
    cyc(8'h28, 1'b0, "R10");
    chkPin(1'b1, "R10");
    cyc(8'h00, 1'b1, "R10");

    // R5 active low
    wr(2'd1, 8'h03);
    chkPin(1'b1, "R5");
    cyc(8'h08, 1'b0, "R5");
    chkPin(1'b0, "R5");
    cyc(8'h00, 1'b1, "R5");
    chkPin(1'b1, "R5");

    // R9 alternate pin function
    wr(2'd1, 8'h04);
    @(negedge clk) bufEmpty = 1'b1;
    chkPin(1'b1, "R9");
    @(negedge clk) bufEmpty = 1'b0;
    chkPin(1'b0, "R9");
    cyc(8'h08, 1'b0, "R9");
    chkPin(1'b0, "R9");
    wr(2'd1, 8'h00);
    chkPin(1'b1, "R9");
    cyc(8'h00, 1'b1, "R9");
    chkPin(1'b0, "R9");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule